// File: doc/BRIEF.md
# Ping-Pong Character Row Store with DMA Refill

This block holds two character row stores of 80 entries each and uses them alternately. One store feeds the character generator. Its 7-bit code is picked by the character position the display timing presents. While that happens, the other store is refilled with the next row from system memory through a DMA request and acknowledge handshake. At every row boundary the two stores change roles. The new row is then visible on the character code output from the following cycle.

Filling a frame starts with a frame-start pulse, which the raster timing issues during vertical retrace, so the first row is loaded before display begins. The request is paced in bursts of 1, 2, 4 or 8 transfers. A programmable idle gap of character clocks separates the bursts. The row length and the number of rows in the frame are both programmable. After the last row of the frame has been swapped in, the block asks for nothing more.

A row boundary that arrives before the fill store is complete is an underrun. The block raises a sticky flag and stops requesting for the rest of the frame.

Top module: `rowbuf_pingpong`

## Requirements
- R1: `char_code` equals the 7-bit value written at index `char_pos` in the store currently on display. A `char_pos` of 80 or more gives 0.
- R2: A `frame_start` pulse resets the fill index and the row tally and clears `underrun`. With `row_len` ≥ 1 and `rows_per_frame` ≥ 1, `dma_req` is high in the cycle after the pulse. A write in the same cycle as `frame_start` or `row_start` is discarded.
- R3: A write is taken when `dma_ack_n` and `wr_n` are both low in the same cycle while a fill is in progress. It goes to the next free index of the fill store, counting up from 0. A `wr_n` strobe while `dma_ack_n` is high is ignored.
- R4: A burst holds 2^`burst_sel` transfers (`burst_sel` 0..3 gives 1, 2, 4, 8). The last burst of a row holds whatever remains. After the last write of a burst that leaves the row incomplete, `dma_req` is low for exactly `burst_gap`+1 cycles and then high again.
- R5: Once `row_len` bytes (values above 80 act as 80) have been taken, `dma_req` stays low until the next swap or frame start.
- R6: A `row_start` pulse with a complete fill swaps the stores. From the next cycle the new row is on `char_code`, and unless the frame is finished `dma_req` rises to refill the other store.
- R7: Writes into the fill store never change `char_code` for the store on display.
- R8: A `row_start` pulse while the fill is incomplete sets `underrun` in the next cycle. The flag holds until the next `frame_start`. There is no swap and `dma_req` stays low meanwhile.
- R9: After `rows_per_frame` swaps in a frame, `dma_req` stays low. Further `row_start` pulses neither swap nor raise `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse in vertical retrace that begins the fill of a frame |
| row_start | input | 1 | One-cycle pulse at each display row boundary, first row included |
| row_len | input | 7 | Characters per row, 1 to 80 |
| rows_per_frame | input | 6 | Rows per frame, at least 1 |
| burst_sel | input | 2 | Burst size select: 1, 2, 4 or 8 transfers |
| burst_gap | input | 4 | Extra idle cycles between bursts |
| dma_req | output | 1 | High while the block wants a transfer |
| dma_ack_n | input | 1 | Active-low DMA cycle marker |
| wr_n | input | 1 | Active-low write strobe for a character |
| wr_data | input | 7 | Character code carried by the write |
| char_pos | input | 7 | Character position being displayed |
| char_code | output | 7 | Code for the character generator |
| underrun | output | 1 | Sticky fill-too-late flag, cleared by frame start |

## Verification
Full rows are loaded under each burst size with gaps from zero to fifteen. Every burst's length and every gap's width are measured against the programmed values, which separates a wrong burst count from a wrong gap count. A half-filled store is read back during its fill to show that the displayed row is isolated from the store being written. A late row boundary, a frame that runs past its last row, and stray strobes without acknowledge tell an underrun apart from a normal end of frame and from ignored traffic. Random frames with random lengths and data then compare every displayed position against a bench model.

// File: rtl/rowbuf_pkg.sv
// Shared definitions for the ping-pong row store.
// Assumes burst select values index powers of two.
package rowbuf_pkg;

    // Index of one of the two character stores.
    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

    // Returns the burst length for a select code: 1 << sel.
    function automatic int unsigned burst_len(input int unsigned sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/rowbuf_bank.sv
// One character store: a synchronous write port and an asynchronous read port.
// Assumes the write address is always below DEPTH. Reads at or above DEPTH return 0.
module rowbuf_bank #(
    parameter int DEPTH = 80,
    parameter int W     = 7,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one character on a write enable.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the addressed character, or zero outside the row.
    always_comb begin
        rdata = '0;
        if (32'(raddr) < DEPTH) rdata = mem[raddr];
    end
endmodule

// File: rtl/rowbuf_pacer.sv
// Paces the DMA request: bursts of 2^burst_sel writes separated by burst_gap+1 idle cycles.
// Assumes 'clear' is pulsed whenever a new row fill begins.
module rowbuf_pacer
    import rowbuf_pkg::*;
#(
    parameter int GAP_W  = 4,
    parameter int BSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              want,
    input  logic              wr_take,
    input  logic [BSEL_W-1:0] burst_sel,
    input  logic [GAP_W-1:0]  burst_gap,
    output logic              req
);
    localparam int BCNT_W = (1 << BSEL_W);

    logic [BCNT_W-1:0] burst_cnt;
    logic [GAP_W:0]    gap_cnt;
    logic [BCNT_W-1:0] blen;

    // Burst length for the current select code.
    always_comb blen = BCNT_W'(burst_len(32'(burst_sel)));

    // Count writes inside a burst and load the idle gap when a burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            burst_cnt <= '0;
            gap_cnt   <= '0;
        end else if (wr_take) begin
            if (burst_cnt + BCNT_W'(1) >= blen) begin
                burst_cnt <= '0;
                gap_cnt   <= {1'b0, burst_gap} + (GAP_W+1)'(1);
            end else begin
                burst_cnt <= burst_cnt + BCNT_W'(1);
            end
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - (GAP_W+1)'(1);
        end
    end

    // Request only while a fill is wanted and no gap is running.
    assign req = want && (gap_cnt == '0);
endmodule

// File: rtl/rowbuf_pingpong.sv
// Ping-pong character row store: one bank feeds the display while the other is
// refilled over DMA, and the roles swap at each row boundary.
// Assumes frame_start and row_start are single-cycle pulses from the raster timing.
module rowbuf_pingpong
    import rowbuf_pkg::*;
#(
    parameter int ROW_CHARS = 80,
    parameter int CODE_W    = 7,
    parameter int ROWS_W    = 6,
    parameter int GAP_W     = 4,
    parameter int BSEL_W    = 2,
    parameter int POS_W     = $clog2(ROW_CHARS),
    parameter int LEN_W     = $clog2(ROW_CHARS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              row_start,
    input  logic [LEN_W-1:0]  row_len,
    input  logic [ROWS_W-1:0] rows_per_frame,
    input  logic [BSEL_W-1:0] burst_sel,
    input  logic [GAP_W-1:0]  burst_gap,
    output logic              dma_req,
    input  logic              dma_ack_n,
    input  logic              wr_n,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [POS_W-1:0]  char_pos,
    output logic [CODE_W-1:0] char_code,
    output logic              underrun
);
    bank_e             disp_bank;
    logic              active;
    logic [LEN_W-1:0]  fill_cnt;
    logic [ROWS_W-1:0] rows_done;
    logic [LEN_W-1:0]  eff_len;
    logic              fill_full;
    logic              wr_take;
    logic              swap;
    logic [CODE_W-1:0] bank_rd [2];

    // Limit the programmed row length to the store depth.
    always_comb eff_len = (row_len > LEN_W'(ROW_CHARS)) ? LEN_W'(ROW_CHARS) : row_len;

    assign fill_full = (fill_cnt >= eff_len);
    assign wr_take   = active && !fill_full && !dma_ack_n && !wr_n
                       && !frame_start && !row_start;
    assign swap      = !frame_start && row_start && active && fill_full;

    // Frame, swap and underrun control for the two stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_bank <= BANK_A;
            active    <= 1'b0;
            fill_cnt  <= '0;
            rows_done <= '0;
            underrun  <= 1'b0;
        end else if (frame_start) begin
            active    <= (rows_per_frame != '0);
            fill_cnt  <= '0;
            rows_done <= '0;
            underrun  <= 1'b0;
        end else if (row_start && active) begin
            if (!fill_full) begin
                underrun <= 1'b1;
                active   <= 1'b0;
            end else begin
                disp_bank <= bank_e'(~disp_bank);
                fill_cnt  <= '0;
                rows_done <= rows_done + ROWS_W'(1);
                if (rows_done + ROWS_W'(1) == rows_per_frame) active <= 1'b0;
            end
        end else if (wr_take) begin
            fill_cnt <= fill_cnt + LEN_W'(1);
        end
    end

    // Two stores; the one not on display takes the writes.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        rowbuf_bank #(
            .DEPTH(ROW_CHARS),
            .W    (CODE_W),
            .AW   (POS_W)
        ) u_bank (
            .clk  (clk),
            .we   (wr_take && (disp_bank != bank_e'(g))),
            .waddr(POS_W'(fill_cnt)),
            .wdata(wr_data),
            .raddr(char_pos),
            .rdata(bank_rd[g])
        );
    end

    // Present the displayed store's character.
    assign char_code = bank_rd[disp_bank];

    rowbuf_pacer #(
        .GAP_W (GAP_W),
        .BSEL_W(BSEL_W)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start || swap),
        .want     (active && !fill_full),
        .wr_take  (wr_take),
        .burst_sel(burst_sel),
        .burst_gap(burst_gap),
        .req      (dma_req)
    );
endmodule

// File: rtl/rowbuf_pingpong_chk.sv
// Port-level property checker for rowbuf_pingpong, attached with bind.
module rowbuf_pingpong_chk #(
    parameter int CODE_W = 7,
    parameter int ROWS_W = 6,
    parameter int POS_W  = 7,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              row_start,
    input logic [LEN_W-1:0]  row_len,
    input logic [ROWS_W-1:0] rows_per_frame,
    input logic              dma_req,
    input logic [POS_W-1:0]  char_pos,
    input logic [CODE_W-1:0] char_code,
    input logic              underrun
);
    // Underrun holds until a frame start.
    assert_underrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !frame_start |=> underrun);

    // No request while underrun is flagged.
    assert_no_req_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !dma_req);

    // Underrun only follows a row boundary.
    assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(row_start));

    // A frame start with a valid format raises the request and clears underrun.
    assert_frame_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && row_len != '0 && rows_per_frame != '0 |=> dma_req && !underrun);

    // Display output only moves with its position or after a row boundary.
    assert_display_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(row_start) && $stable(char_pos) |-> $stable(char_code));
endmodule

bind rowbuf_pingpong rowbuf_pingpong_chk #(
    .CODE_W(CODE_W),
    .ROWS_W(ROWS_W),
    .POS_W (POS_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .row_start     (row_start),
    .row_len       (row_len),
    .rows_per_frame(rows_per_frame),
    .dma_req       (dma_req),
    .char_pos      (char_pos),
    .char_code     (char_code),
    .underrun      (underrun)
);

// File: tb/sim_rowbuf_pingpong.sv
module sim_rowbuf_pingpong;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       row_start = 1'b0;
    logic [6:0] row_len = 7'd80;
    logic [5:0] rows_per_frame = 6'd3;
    logic [1:0] burst_sel = 2'd0;
    logic [3:0] burst_gap = 4'd0;
    logic       dma_req;
    logic       dma_ack_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [6:0] wr_data = '0;
    logic [6:0] char_pos = '0;
    logic [6:0] char_code;
    logic       underrun;

    int n_chk = 0;
    int n_fail = 0;
    bit [6:0] exp_disp [80];
    bit [6:0] exp_fill [80];

    rowbuf_pingpong u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_start(row_start),
        .row_len(row_len), .rows_per_frame(rows_per_frame), .burst_sel(burst_sel),
        .burst_gap(burst_gap), .dma_req(dma_req), .dma_ack_n(dma_ack_n), .wr_n(wr_n),
        .wr_data(wr_data), .char_pos(char_pos), .char_code(char_code), .underrun(underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int exp_run(input int bsel, input int rem);
        return ((1 << bsel) < rem) ? (1 << bsel) : rem;
    endfunction

    // Acts as the DMA side; writes cnt bytes starting at index first, checking pacing.
    task automatic fill_row(input int first, input int len, input int cnt, input bit pace);
        int done = 0;
        int run = 0;
        int low = 0;
        int rem = 0;
        while (done < cnt) begin
            @(negedge clk);
            if (dma_req) begin
                if (run == 0) begin
                    if ((first + done) > 0 && pace && low > 0) chk("R4 gap", low, burst_gap + 1);
                    rem = len - (first + done);
                    low = 0;
                end
                wr_data = 7'($urandom);
                exp_fill[first + done] = wr_data;
                dma_ack_n = 1'b0;
                wr_n = 1'b0;
                done++;
                run++;
            end else begin
                dma_ack_n = 1'b1;
                wr_n = 1'b1;
                if (run > 0) begin
                    if (pace) chk("R4 burst", run, exp_run(burst_sel, rem));
                    run = 0;
                end
                low++;
                if (low > 300) begin
                    chk("R4 request timeout", 0, 1);
                    return;
                end
            end
        end
        @(negedge clk);
        dma_ack_n = 1'b1;
        wr_n = 1'b1;
        if (first + done == len) begin
            if (pace && run > 0) chk("R4 last burst", run, exp_run(burst_sel, rem));
            chk("R5 req low when full", dma_req, 0);
        end
    endtask

    task automatic pulse_row();
        @(negedge clk) row_start = 1'b1;
        @(negedge clk) row_start = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic check_display(input string tag, input int len);
        for (int p = 0; p < len; p++) begin
            char_pos = 7'(p);
            #1;
            chk(tag, char_code, exp_disp[p]);
        end
        char_pos = '0;
    endtask

    task automatic swap_model();
        for (int i = 0; i < 80; i++) exp_disp[i] = exp_fill[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R4 R5 actual=timeout expected=finish");
        report();
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset req", dma_req, 0);
        chk("R8 reset underrun", underrun, 0);

        // Frame with a simultaneous stray write; stray strobes without ack.
        row_len = 7'd80; rows_per_frame = 6'd3; burst_sel = 2'd2; burst_gap = 4'd3;
        dma_ack_n = 1'b0; wr_n = 1'b0; wr_data = 7'h55;
        pulse_frame();
        dma_ack_n = 1'b1;
        chk("R2 req after frame start", dma_req, 1);
        wr_n = 1'b0; wr_data = 7'h2A;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        fill_row(0, 80, 80, 1);
        repeat (4) @(negedge clk);
        chk("R5 req stays low", dma_req, 0);
        pulse_row();
        swap_model();
        chk("R6 refill request", dma_req, 1);
        check_display("R1 R3 row0 content", 80);
        char_pos = 7'd80; #1; chk("R1 pos 80", char_code, 0);
        char_pos = 7'd127; #1; chk("R1 pos 127", char_code, 0);
        char_pos = '0;

        // Second row, burst 1, no gap, display checked mid-fill.
        burst_sel = 2'd0; burst_gap = 4'd0;
        fill_row(0, 80, 40, 1);
        check_display("R7 display during fill", 80);
        fill_row(40, 80, 40, 1);
        check_display("R7 display after fill", 80);
        pulse_row();
        swap_model();
        check_display("R6 row1 content", 80);

        // Last row of frame, burst 8.
        burst_sel = 2'd3; burst_gap = 4'd1;
        fill_row(0, 80, 80, 1);
        pulse_row();
        swap_model();
        check_display("R6 row2 content", 80);
        repeat (5) @(negedge clk);
        chk("R9 no req after last row", dma_req, 0);
        pulse_row();
        chk("R9 no underrun past frame", underrun, 0);
        check_display("R9 no swap past frame", 80);

        // Underrun on a late fill.
        row_len = 7'd20; rows_per_frame = 6'd4; burst_sel = 2'd1; burst_gap = 4'd2;
        pulse_frame();
        fill_row(0, 20, 20, 1);
        pulse_row();
        swap_model();
        check_display("R6 short row", 20);
        fill_row(0, 20, 5, 0);
        pulse_row();
        chk("R8 underrun set", underrun, 1);
        chk("R8 no req", dma_req, 0);
        check_display("R8 display kept", 20);
        repeat (10) @(negedge clk);
        chk("R8 underrun held", underrun, 1);
        pulse_frame();
        chk("R8 cleared by frame", underrun, 0);
        chk("R2 req after underrun frame", dma_req, 1);

        // Random frames.
        for (int f = 0; f < 8; f++) begin
            row_len = 7'($urandom_range(1, 80));
            burst_sel = 2'($urandom_range(0, 3));
            burst_gap = 4'($urandom_range(0, 15));
            rows_per_frame = 6'd2;
            pulse_frame();
            for (int r = 0; r < 2; r++) begin
                fill_row(0, int'(row_len), int'(row_len), 1);
                pulse_row();
                swap_model();
                check_display("R1 R6 random row", int'(row_len));
            end
            @(negedge clk);
            chk("R9 random frame end", dma_req, 0);
        end

        report();
    end
endmodule